// File: doc/BRIEF.md
# Timer Input Capture Unit

This block freezes the value of a free-running 16-bit timer count when an event arrives, and makes that frozen value available to a processor over an 8-bit register bus. The event comes from one of two inputs: a dedicated capture pin, or an analog comparator output. A control bit picks which one is used. The chosen input passes through a two-stage synchronizer, and a rising edge of the synchronized level triggers the snapshot. The same edge sets a capture flag. The stored value can also be handed to the counter logic as its wrap-around limit, in place of the all-ones maximum.

Because the bus is only 8 bits wide, 16-bit transfers pass through a single staging byte. This byte is shared with the other 16-bit timer registers, which reach it through a side port.
- Reading the low half returns the low byte and, at the same clock edge, parks the matching high byte in the staging byte. A following high-half read returns that parked byte.
- Writing the high half only fills the staging byte. A following low-half write commits both bytes in one step.

The block also holds the interrupt enable bits for four timer sources: capture, compare B, compare A and overflow. Each request goes out only when all three of these are true: its flag is set, its enable bit is set, and the global interrupt enable is high.

Top module: `tmr_icap`

## Requirements
- R1: The snapshot register loads `cnt_i` at the third rising clock edge after the selected source goes high, because of two synchronizer stages and one edge-detect stage. Only one snapshot is taken per rising edge of the source.
- R2: Control register at 0x2E, bit 0, selects the capture source. 0 selects `cap_pin_i` and 1 selects `acmp_i`. Edges on the source that is not selected have no effect.
- R3: A read at 0x22 returns the snapshot bits [7:0] in the same cycle, and at that edge loads the staging byte with snapshot bits [15:8]. A read at 0x23 returns the staging byte.
- R4: A write at 0x23 loads only the staging byte, and the snapshot stays unchanged. A write at 0x22 sets the snapshot to {staging byte, write data}.
- R5: The staging byte appears on `shr_tmp_q_o`. A pulse on `shr_tmp_we_i` loads it from `shr_tmp_wdata_i` when the bus is not using it in that cycle.
- R6: The enable register at 0x2B has writable bits 5 (capture), 2 (compare B), 1 (compare A) and 0 (overflow). Bits 7, 6, 4 and 3 always read 0.
- R7: `irq_o[0]`, `irq_o[1]`, `irq_o[2]` and `irq_o[3]` belong to overflow, compare A, compare B and capture, in that order. Each is high only when its flag, its enable bit and `gie_i` are all set.
- R8: The flag register at 0x2A shows the capture flag in bit 5 and the external overflow, compare A and compare B flags in bits 0, 1 and 2. The capture flag is cleared by writing 1 to bit 5 or by pulsing `cap_ack_i`. A capture in the same cycle wins over either clear.
- R9: Control register bit 1 selects `top_o`: the snapshot when 1, 16'hFFFF when 0.
- R10: After synchronous reset, the snapshot, staging byte, enables, capture flag and control register are all 0, `top_o` is 16'hFFFF, and `irq_o` is 0.
- R11: When a capture and a write at 0x22 happen in the same cycle, the snapshot takes the counter value.
- R12: `bus_rdata` is 0 when `bus_re` is low or the address is not mapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data (combinational) |
| cnt_i | input | 16 | Current timer count |
| cap_pin_i | input | 1 | Capture pin |
| acmp_i | input | 1 | Analog comparator output |
| ovf_flag_i | input | 1 | Overflow flag from the counter |
| cmpa_flag_i | input | 1 | Compare A flag |
| cmpb_flag_i | input | 1 | Compare B flag |
| gie_i | input | 1 | Global interrupt enable |
| cap_ack_i | input | 1 | Capture interrupt acknowledge |
| shr_tmp_we_i | input | 1 | Staging byte load from another 16-bit register |
| shr_tmp_wdata_i | input | 8 | Data for that load |
| shr_tmp_q_o | output | 8 | Staging byte |
| top_o | output | 16 | Counter limit |
| irq_o | output | 4 | Gated interrupt requests |

## Verification
The results of this block fall due at different cycles.

| Result | When it is due |
|---|---|
| Snapshot and capture flag | Third rising edge after the source rises |
| Read data | Combinational, during the read cycle |
| Staging byte loaded by a read | At the edge that ends the read |
| Effect of a write | After the edge that ends the write |
| Requests | Combinational from the registered flags and enables |

The bench changes inputs on falling edges and samples one nanosecond later. It probes the flag and `irq_o` at the negedges after the second and third posedges to pin down the capture latency. The stimulus is held long enough, and the counter held constant, that each expected value is unambiguous.

// File: rtl/icap_pkg.sv
package icap_pkg;
    localparam int DW     = 8;
    localparam int CW     = 2 * DW;
    localparam int AW     = 6;
    localparam int NSRC   = 4;

    localparam logic [AW-1:0] ADR_SNAP_LO = 6'h22;
    localparam logic [AW-1:0] ADR_SNAP_HI = 6'h23;
    localparam logic [AW-1:0] ADR_FLAGS   = 6'h2A;
    localparam logic [AW-1:0] ADR_ENABLE  = 6'h2B;
    localparam logic [AW-1:0] ADR_CTRL    = 6'h2E;

    localparam int BIT_OVF  = 0;
    localparam int BIT_CMPA = 1;
    localparam int BIT_CMPB = 2;
    localparam int BIT_CAP  = 5;

    localparam logic [DW-1:0] ENABLE_WMASK = 8'h27;
    localparam logic [DW-1:0] CTRL_WMASK   = 8'h03;
    localparam int CTRL_SRC = 0;
    localparam int CTRL_TOP = 1;
    localparam logic [CW-1:0] TOP_MAX = '1;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_SNAP_LO, SEL_SNAP_HI, SEL_FLAGS, SEL_ENABLE, SEL_CTRL
    } reg_sel_e;

    typedef struct packed {
        logic          rd;
        logic          wr;
        reg_sel_e      sel;
        logic [DW-1:0] data;
    } bus_req_t;

    function automatic reg_sel_e decode_addr(input logic [AW-1:0] a);
        case (a)
            ADR_SNAP_LO: return SEL_SNAP_LO;
            ADR_SNAP_HI: return SEL_SNAP_HI;
            ADR_FLAGS:   return SEL_FLAGS;
            ADR_ENABLE:  return SEL_ENABLE;
            ADR_CTRL:    return SEL_CTRL;
            default:     return SEL_NONE;
        endcase
    endfunction

    // request line index -> bit position in flag/enable registers
    function automatic int src_bit(input int idx);
        case (idx)
            0:       return BIT_OVF;
            1:       return BIT_CMPA;
            2:       return BIT_CMPB;
            default: return BIT_CAP;
        endcase
    endfunction
endpackage

// File: rtl/icap_edge_det.sv
module icap_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int N = (STAGES < 1) ? 1 : STAGES;

    logic [N-1:0] sync_q;
    logic         last_q;

    generate
        if (N == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[N-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[N-1];
    end

    assign rise = sync_q[N-1] & ~last_q;

    // R1: one snapshot per source edge
    assert_single_rise_R1: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/icap_hold_reg.sv
module icap_hold_reg
    import icap_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          evt,
    input  logic [CW-1:0] cnt,
    input  bus_req_t      req,
    input  logic          shr_we,
    input  logic [DW-1:0] shr_wdata,
    output logic [CW-1:0] snap_q,
    output logic [DW-1:0] tmp_q,
    output logic [DW-1:0] rdata
);
    logic wr_lo, wr_hi, rd_lo, rd_hi;

    assign wr_lo = req.wr && (req.sel == SEL_SNAP_LO);
    assign wr_hi = req.wr && (req.sel == SEL_SNAP_HI);
    assign rd_lo = req.rd && (req.sel == SEL_SNAP_LO);
    assign rd_hi = req.rd && (req.sel == SEL_SNAP_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else if (evt) begin
            snap_q <= cnt;
        end else if (wr_lo) begin
            snap_q <= {tmp_q, req.data};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmp_q <= '0;
        end else if (wr_hi) begin
            tmp_q <= req.data;
        end else if (rd_lo) begin
            tmp_q <= snap_q[CW-1:DW];
        end else if (shr_we) begin
            tmp_q <= shr_wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_lo)      rdata = snap_q[DW-1:0];
        else if (rd_hi) rdata = tmp_q;
    end

    assert_snap_load_R1: assert property (@(posedge clk) disable iff (rst)
        evt |=> snap_q == $past(cnt));
    assert_lo_commit_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !evt) |=> snap_q == {$past(tmp_q), $past(req.data)});
    assert_hi_write_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && !evt) |=> $stable(snap_q));
    assert_lo_read_stage_R3: assert property (@(posedge clk) disable iff (rst)
        rd_lo |=> tmp_q == $past(snap_q[CW-1:DW]));
endmodule

// File: rtl/icap_irq_ctrl.sv
module icap_irq_ctrl
    import icap_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            evt,
    input  logic            ack,
    input  logic            gie,
    input  logic            ovf_flag,
    input  logic            cmpa_flag,
    input  logic            cmpb_flag,
    input  bus_req_t        req,
    output logic [NSRC-1:0] irq,
    output logic [DW-1:0]   rdata
);
    logic [DW-1:0] enable_q;
    logic          cap_flag_q;
    logic [DW-1:0] flag_vec;
    logic          sw_clear;

    assign sw_clear = req.wr && (req.sel == SEL_FLAGS) && req.data[BIT_CAP];

    always_ff @(posedge clk) begin
        if (rst)                                      enable_q <= '0;
        else if (req.wr && (req.sel == SEL_ENABLE))   enable_q <= req.data & ENABLE_WMASK;
    end

    always_ff @(posedge clk) begin
        if (rst)                  cap_flag_q <= 1'b0;
        else if (evt)             cap_flag_q <= 1'b1;
        else if (sw_clear || ack) cap_flag_q <= 1'b0;
    end

    always_comb begin
        flag_vec           = '0;
        flag_vec[BIT_OVF]  = ovf_flag;
        flag_vec[BIT_CMPA] = cmpa_flag;
        flag_vec[BIT_CMPB] = cmpb_flag;
        flag_vec[BIT_CAP]  = cap_flag_q;
    end

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_req
            localparam int P = src_bit(i);
            assign irq[i] = gie & enable_q[P] & flag_vec[P];
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (req.rd && (req.sel == SEL_ENABLE)) rdata = enable_q;
        else if (req.rd && (req.sel == SEL_FLAGS)) rdata = flag_vec;
    end

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
        evt |=> cap_flag_q);
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
        ((sw_clear || ack) && !evt) |=> !cap_flag_q);
endmodule

// File: rtl/tmr_icap.sv
module tmr_icap
    import icap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic            bus_we,
    input  logic            bus_re,
    output logic [DW-1:0]   bus_rdata,
    input  logic [CW-1:0]   cnt_i,
    input  logic            cap_pin_i,
    input  logic            acmp_i,
    input  logic            ovf_flag_i,
    input  logic            cmpa_flag_i,
    input  logic            cmpb_flag_i,
    input  logic            gie_i,
    input  logic            cap_ack_i,
    input  logic            shr_tmp_we_i,
    input  logic [DW-1:0]   shr_tmp_wdata_i,
    output logic [DW-1:0]   shr_tmp_q_o,
    output logic [CW-1:0]   top_o,
    output logic [NSRC-1:0] irq_o
);
    bus_req_t      req;
    logic [DW-1:0] ctrl_q;
    logic          src_lvl;
    logic          cap_evt;
    logic [CW-1:0] snap_q;
    logic [DW-1:0] rd_hold, rd_irq, rd_ctrl;

    always_comb begin
        req.rd   = bus_re;
        req.wr   = bus_we;
        req.sel  = decode_addr(bus_addr);
        req.data = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                                 ctrl_q <= '0;
        else if (req.wr && req.sel == SEL_CTRL)  ctrl_q <= req.data & CTRL_WMASK;
    end

    assign src_lvl = ctrl_q[CTRL_SRC] ? acmp_i : cap_pin_i;

    icap_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (src_lvl),
        .rise (cap_evt)
    );

    icap_hold_reg u_hold (
        .clk       (clk),
        .rst       (rst),
        .evt       (cap_evt),
        .cnt       (cnt_i),
        .req       (req),
        .shr_we    (shr_tmp_we_i),
        .shr_wdata (shr_tmp_wdata_i),
        .snap_q    (snap_q),
        .tmp_q     (shr_tmp_q_o),
        .rdata     (rd_hold)
    );

    icap_irq_ctrl u_irq (
        .clk       (clk),
        .rst       (rst),
        .evt       (cap_evt),
        .ack       (cap_ack_i),
        .gie       (gie_i),
        .ovf_flag  (ovf_flag_i),
        .cmpa_flag (cmpa_flag_i),
        .cmpb_flag (cmpb_flag_i),
        .req       (req),
        .irq       (irq_o),
        .rdata     (rd_irq)
    );

    assign rd_ctrl   = (req.rd && req.sel == SEL_CTRL) ? ctrl_q : '0;
    assign bus_rdata = rd_hold | rd_irq | rd_ctrl;
    assign top_o     = ctrl_q[CTRL_TOP] ? snap_q : TOP_MAX;

    // R12: idle bus returns zero
    assert_idle_rdata_R12: assert property (@(posedge clk) disable iff (rst)
        !bus_re |-> bus_rdata == '0);
endmodule

// File: tb/tmr_icap_tb.sv
module tmr_icap_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic [5:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 0, bus_re = 0;
    logic [7:0]  bus_rdata;
    logic [15:0] cnt = '0;
    logic        pin = 0, acmp = 0;
    logic        ovf = 0, cmpa = 0, cmpb = 0, gie = 0, ack = 0;
    logic        shr_we = 0;
    logic [7:0]  shr_wdata = '0;
    logic [7:0]  shr_q;
    logic [15:0] top;
    logic [3:0]  irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    tmr_icap u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .cnt_i(cnt),
        .cap_pin_i(pin), .acmp_i(acmp), .ovf_flag_i(ovf), .cmpa_flag_i(cmpa),
        .cmpb_flag_i(cmpb), .gie_i(gie), .cap_ack_i(ack), .shr_tmp_we_i(shr_we),
        .shr_tmp_wdata_i(shr_wdata), .shr_tmp_q_o(shr_q), .top_o(top), .irq_o(irq)
    );

    // {source select, counter value}
    localparam logic [16:0] VEC [6] = '{
        {1'b0, 16'h1234}, {1'b1, 16'hBEEF}, {1'b0, 16'h00FF},
        {1'b1, 16'hFF00}, {1'b0, 16'hFFFF}, {1'b1, 16'h0001}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 0;
    endtask

    task automatic pulse(input bit use_cmp);
        @(negedge clk);
        if (use_cmp) acmp = 1; else pin = 1;
        repeat (4) @(negedge clk);
        acmp = 0; pin = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [7:0] d, lo;
        repeat (3) @(negedge clk);
        rst = 0;

        // R10 reset state
        rd(6'h22, d); chk("R10 snap lo", d, 0);
        rd(6'h23, d); chk("R10 stage", d, 0);
        rd(6'h2B, d); chk("R10 enable", d, 0);
        rd(6'h2A, d); chk("R10 flags", d, 0);
        rd(6'h2E, d); chk("R10 ctrl", d, 0);
        #1 chk("R10 top", top, 16'hFFFF);
        chk("R10 irq", irq, 0);

        // table walk: R1 R2 R3 R8
        for (int i = 0; i < 6; i++) begin
            wr(6'h2E, {7'b0, VEC[i][16]});
            cnt = VEC[i][15:0];
            pulse(!VEC[i][16]);
            rd(6'h2A, d); chk("R2 unselected source ignored", d[5], 0);
            pulse(VEC[i][16]);
            rd(6'h2A, d); chk("R1 flag after capture", d[5], 1);
            rd(6'h22, lo); chk("R3 low byte", lo, VEC[i][7:0]);
            rd(6'h23, d);  chk("R3 high byte via stage", d, VEC[i][15:8]);
            wr(6'h2A, 8'h20);
            rd(6'h2A, d); chk("R8 write-one clear", d[5], 0);
        end

        // R6 enable register
        wr(6'h2B, 8'hFF);
        rd(6'h2B, d); chk("R6 reserved bits zero", d, 8'h27);

        // R7 gating
        ovf = 1; cmpa = 1; cmpb = 1; gie = 0;
        #1 chk("R7 gie low", irq, 0);
        rd(6'h2A, d); chk("R8 external flag bits", d, 8'h07);
        gie = 1;
        #1 chk("R7 all enabled", irq, 4'b0111);
        wr(6'h2B, 8'h02);
        #1 chk("R7 only compare A", irq, 4'b0010);
        ovf = 0; cmpa = 0; cmpb = 0;
        wr(6'h2B, 8'h20);

        // R1 latency on pin
        wr(6'h2E, 8'h00);
        cnt = 16'h4242;
        @(negedge clk); pin = 1;
        @(negedge clk); @(negedge clk);
        #1 chk("R1 not yet after two edges", irq[3], 0);
        @(negedge clk);
        #1 chk("R1 request at third edge", irq[3], 1);
        pin = 0;
        // R8 acknowledge
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0;
        #1 chk("R8 ack clears", irq[3], 0);
        chk("R7 gated requests after ack", irq, 0);

        // R8 set wins over clear
        @(negedge clk); pin = 1;
        @(negedge clk); @(negedge clk);
        bus_addr = 6'h2A; bus_wdata = 8'h20; bus_we = 1;
        @(negedge clk); bus_we = 0; pin = 0;
        #1 chk("R8 capture beats clear", irq[3], 1);
        wr(6'h2A, 8'h20);
        gie = 0;

        // R9 / R4
        wr(6'h2E, 8'h02);
        #1 chk("R9 top follows snapshot", top, 16'h4242);
        wr(6'h23, 8'hA5);
        #1 chk("R4 high write keeps snapshot", top, 16'h4242);
        chk("R5 stage visible", shr_q, 8'hA5);
        wr(6'h22, 8'h5A);
        #1 chk("R4 low write commits", top, 16'hA55A);

        // R5 shared load
        @(negedge clk); shr_we = 1; shr_wdata = 8'h3C;
        @(negedge clk); shr_we = 0;
        #1 chk("R5 side load", shr_q, 8'h3C);
        wr(6'h22, 8'h11);
        #1 chk("R5 commit with side byte", top, 16'h3C11);

        // R11 capture beats low write
        cnt = 16'h7E81;
        @(negedge clk); pin = 1;
        @(negedge clk); @(negedge clk);
        bus_addr = 6'h22; bus_wdata = 8'h99; bus_we = 1;
        @(negedge clk); bus_we = 0; pin = 0;
        #1 chk("R11 capture wins", top, 16'h7E81);
        wr(6'h2E, 8'h00);
        #1 chk("R9 fixed maximum", top, 16'hFFFF);

        // R12
        rd(6'h10, d); chk("R12 unmapped", d, 0);
        @(negedge clk); bus_addr = 6'h22; bus_re = 0;
        #1 chk("R12 no read strobe", bus_rdata, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule